// File: doc/BRIEF.md
# Thermal clock modulation controller

This block slows a processor core when it runs hot by switching the core clock enable on and off. A digital die temperature (unsigned, in whole degrees Celsius) is compared against a fixed trip level and a fixed critical level. Above the trip level an automatic throttle starts. A software-controlled on-demand throttle can also run at any temperature. Both throttles divide time into a repeating frame of eight slots. A slot lasts `presc + 1` clock cycles. A duty code N means the clock runs for the first N slots of the frame and is gated for the rest.

Automatic throttling always uses a half duty cycle. It has a release level below the trip level, so it does not chatter when the temperature hovers near the trip point. Automatic throttling overrides on-demand throttling. The on-demand duty code is taken from a 5-bit control write. The block drives an active-low hot flag, which can be held through a low-power state. It also drives an active-low critical flag that stays set until reset. Interrupt requests that arrive while the clock is gated are held, then released in the next clock-on slot.

Top module: `thermclk_throttle`

## Requirements
- R1: After reset, `clk_en`=1, `hot_n`=1, `trip_n`=1, on-demand mode is off with duty code 0, nothing is held pending, and the slot count and frame count are 0.
- R2: One cycle after `temp` >= TRIP (100), automatic throttling is active. While it is active, `clk_en` is 1 in slots 0 to 3 and 0 in slots 4 to 7 of each 8-slot frame.
- R3: Automatic throttling stays active while `temp` >= TRIP-HYST (98). It releases one cycle after `temp` drops below 98.
- R4: A write with `ctl_we`=1 stores `ctl_wdata[4]` as the on-demand enable and `ctl_wdata[3:1]` as the duty code N. Bit 0 is ignored. While the enable is set, `clk_en` is 1 in slots 0 to N-1 and 0 in the remaining slots, whatever the temperature.
- R5: An on-demand duty code of 0 behaves as code 4, which is a 50% duty cycle.
- R6: While automatic throttling is active, the duty cycle is 4 of 8 slots whatever the on-demand code.
- R7: `hot_n` is 0 in the cycle after a cycle with `temp` >= 100. It is 1 in the cycle after a cycle with `temp` < 100 while `lowpwr`=0.
- R8: While `lowpwr`=1, a `hot_n` that is already 0 stays 0. It returns to 1 only after `lowpwr`=0 and `temp` < 100.
- R9: `trip_n` falls one cycle after `temp` >= CRIT (125). It stays 0 until reset, whatever the temperature and mode.
- R10: While `clk_en`=1, `irq_out` equals `irq_in` OR'd with the held requests, and the held requests then clear. While `clk_en`=0, `irq_out` is 0 and each `irq_in` bit is held.
- R11: Each slot lasts `presc`+1 clock cycles, so a frame lasts 8*(`presc`+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp | input | TEMP_W | Die temperature, unsigned °C |
| presc | input | PRE_W | Slot length minus one, in cycles |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data: bit 4 enable, bits 3:1 duty code |
| lowpwr | input | 1 | Low-power state indicator |
| irq_in | input | IRQ_W | Incoming interrupt requests |
| clk_en | output | 1 | Core clock enable |
| hot_n | output | 1 | Active-low over-trip flag |
| trip_n | output | 1 | Active-low sticky critical flag |
| irq_out | output | IRQ_W | Interrupt requests passed to the core |

## Verification
Temperature is varied at random in a narrow band around the trip and release levels. This exercises the hysteresis band from both sides and shows a release level set too high or too low. Every on-demand duty code, including the reserved zero, is measured as the on-cycle count over a full frame at a non-unit prescale. This tells a wrong slot boundary apart from a wrong code decode. A hot run with the highest on-demand code shows whether automatic mode really has priority. Interrupt pulses placed inside gated slots show whether requests are lost, leaked or held.

// File: rtl/thermclk_throttle.sv
module thermclk_throttle #(
  parameter int TEMP_W = 8,
  parameter int TRIP   = 100,
  parameter int CRIT   = 125,
  parameter int HYST   = 2,
  parameter int PRE_W  = 8,
  parameter int IRQ_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp,
  input  logic [PRE_W-1:0]  presc,
  input  logic              ctl_we,
  input  logic [4:0]        ctl_wdata,
  input  logic              lowpwr,
  input  logic [IRQ_W-1:0]  irq_in,
  output logic              clk_en,
  output logic              hot_n,
  output logic              trip_n,
  output logic [IRQ_W-1:0]  irq_out
);
  localparam logic [TEMP_W-1:0] TRIP_T = TEMP_W'(TRIP);
  localparam logic [TEMP_W-1:0] REL_T  = TEMP_W'(TRIP - HYST);
  localparam logic [TEMP_W-1:0] CRIT_T = TEMP_W'(CRIT);
  localparam logic [2:0]        HALF   = 3'd4;

  logic [PRE_W-1:0] pcnt;
  logic [2:0]       slot;
  logic             auto_q, od_en, hot_q, crit_q;
  logic [2:0]       od_code;
  logic [IRQ_W-1:0] pend;

  wire       over   = temp >= TRIP_T;
  wire       wrap   = pcnt >= presc;
  wire [2:0] duty   = auto_q ? HALF : (od_code == 3'd0 ? HALF : od_code);
  wire       gating = auto_q | od_en;

  assign clk_en  = !gating || (slot < duty);
  assign hot_n   = !hot_q;
  assign trip_n  = !crit_q;
  assign irq_out = clk_en ? (irq_in | pend) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt    <= '0;
      slot    <= '0;
      auto_q  <= 1'b0;
      od_en   <= 1'b0;
      od_code <= '0;
      hot_q   <= 1'b0;
      crit_q  <= 1'b0;
      pend    <= '0;
    end else begin
      pcnt <= wrap ? '0 : pcnt + 1'b1;
      if (wrap) slot <= slot + 1'b1;
      if (over)              auto_q <= 1'b1;
      else if (temp < REL_T) auto_q <= 1'b0;
      hot_q  <= lowpwr ? (hot_q | over) : over;
      crit_q <= crit_q | (temp >= CRIT_T);
      if (ctl_we) begin
        od_en   <= ctl_wdata[4];
        od_code <= ctl_wdata[3:1];
      end
      pend <= clk_en ? '0 : (pend | irq_in);
    end
  end

  a_r9_trip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_n |=> !trip_n);
  a_r7_hot_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (temp >= TRIP_T) |=> !hot_n);
  a_r3_hold_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_q && temp >= REL_T) |=> auto_q);
  a_r6_auto_gates_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_q && slot >= HALF) |-> !clk_en);
  a_r10_irq_not_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && |irq_in) |=> (!clk_en || |irq_out));
  a_r8_lowpwr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lowpwr && !hot_n) |=> !hot_n);
endmodule

// File: tb/thermclk_throttle_test.sv
module thermclk_throttle_test;
  localparam int CLK_P = 10;
  localparam int TRIP = 100, CRIT = 125, HYST = 2;

  logic clk = 0, rst_n = 0, ctl_we = 0, lowpwr = 0;
  logic [7:0] temp = 8'd40, presc = 8'd0;
  logic [4:0] ctl_wdata = '0;
  logic [3:0] irq_in = '0;
  logic clk_en, hot_n, trip_n;
  logic [3:0] irq_out;

  int checks = 0, errors = 0;
  bit done = 0;

  thermclk_throttle uut (.clk(clk), .rst_n(rst_n), .temp(temp), .presc(presc),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .lowpwr(lowpwr), .irq_in(irq_in),
    .clk_en(clk_en), .hot_n(hot_n), .trip_n(trip_n), .irq_out(irq_out));

  always #(CLK_P/2) clk = ~clk;

  int m_pc, m_slot, m_dc;
  bit m_auto, m_od, m_hot, m_crit;
  logic [3:0] m_pend;

  function automatic int m_duty();
    if (m_auto) return 4;
    return (m_dc == 0) ? 4 : m_dc;
  endfunction
  function automatic bit exp_clk();
    return !(m_auto || m_od) || (m_slot < m_duty());
  endfunction
  function automatic logic [3:0] exp_irq();
    return exp_clk() ? (irq_in | m_pend) : 4'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_slot = 0; m_dc = 0; m_auto = 0; m_od = 0;
      m_hot = 0; m_crit = 0; m_pend = 0;
    end else begin
      m_pend = exp_clk() ? 4'd0 : (m_pend | irq_in);
      if (m_pc >= presc) begin m_pc = 0; m_slot = (m_slot + 1) % 8; end
      else m_pc++;
      if (temp >= TRIP) m_auto = 1;
      else if (temp < TRIP - HYST) m_auto = 0;
      m_hot = lowpwr ? (m_hot | (temp >= TRIP)) : (temp >= TRIP);
      if (temp >= CRIT) m_crit = 1;
      if (ctl_we) begin m_od = ctl_wdata[4]; m_dc = ctl_wdata[3:1]; end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk(m_auto ? "R2 clk_en" : (m_od ? "R4 clk_en" : "R1 clk_en"), clk_en, exp_clk());
    chk(lowpwr ? "R8 hot_n" : "R7 hot_n", hot_n, !m_hot);
    chk("R9 trip_n", trip_n, !m_crit);
    chk("R10 irq_out", irq_out, exp_irq());
  endtask

  task automatic step();
    @(negedge clk); #1; cmp_all();
  endtask

  task automatic wr(logic [4:0] d);
    @(negedge clk); ctl_we = 1; ctl_wdata = d; #1; cmp_all();
    @(negedge clk); ctl_we = 0; #1; cmp_all();
  endtask

  task automatic do_reset(logic [7:0] p);
    @(negedge clk); rst_n = 0; presc = p; ctl_we = 0; lowpwr = 0; irq_in = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  function automatic int count_frame_on();
    return 0;
  endfunction

  task automatic measure(string tag, int exp_on);
    int on = 0;
    for (int i = 0; i < 8 * (presc + 1); i++) begin
      step();
      if (clk_en) on++;
    end
    chk(tag, on, exp_on);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 clk_en", clk_en, 1); chk("R1 hot_n", hot_n, 1);
    chk("R1 trip_n", trip_n, 1); chk("R1 irq_out", irq_out, 0);
    rst_n = 1;

    do_reset(8'd2);
    temp = 8'd50;
    measure("R1 idle full clock", 24);
    temp = 8'd100; step(); step();
    chk("R7 hot_n set", hot_n, 0);
    measure("R2 auto half duty", 12);
    measure("R11 slot length", 12);
    temp = 8'd98;
    measure("R3 held at release level", 12);
    temp = 8'd97; step(); step();
    measure("R3 released below level", 24);
    chk("R7 hot_n clear", hot_n, 1);

    for (int k = 0; k < 8; k++) begin
      wr({1'b1, 3'(k), 1'b1});
      measure(k == 0 ? "R5 reserved code" : "R4 od duty", (k == 0 ? 4 : k) * 3);
    end
    wr(5'b11110);
    temp = 8'd110; step(); step();
    measure("R6 auto precedence", 12);
    temp = 8'd40; step(); step();
    measure("R4 od code 7 after cool", 21);
    wr(5'b00000);

    do_reset(8'd0);
    temp = 8'd105; step(); step();
    lowpwr = 1; temp = 8'd30;
    for (int i = 0; i < 5; i++) step();
    chk("R8 hot held in low power", hot_n, 0);
    lowpwr = 0; step();
    chk("R8 hot released", hot_n, 1);

    wr(5'b10010);
    while (clk_en) step();
    irq_in = 4'b0010; step();
    chk("R10 gated irq blocked", irq_out, 0);
    irq_in = 4'b0000;
    while (!clk_en) step();
    chk("R10 held irq presented", irq_out, 2);
    step();
    chk("R10 held irq cleared", irq_out, 0);
    wr(5'b00000);

    do_reset(8'd1);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      temp   = 8'(94 + $urandom_range(0, 10));
      lowpwr = ($urandom_range(0, 15) == 0);
      irq_in = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'd0;
      ctl_we = ($urandom_range(0, 63) == 0);
      ctl_wdata = 5'($urandom);
      #1; cmp_all();
    end
    ctl_we = 0; lowpwr = 0; irq_in = 0;

    temp = 8'd125; step(); step();
    chk("R9 trip asserted", trip_n, 0);
    temp = 8'd20;
    for (int i = 0; i < 10; i++) step();
    chk("R9 trip sticky", trip_n, 0);
    do_reset(8'd0); step();
    chk("R9 trip cleared by reset", trip_n, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule